// File: doc/BRIEF.md
# PWM Dead-Band Generator

This block sits between a PWM edge-placement stage and a chopper stage. It takes two PWM inputs, A and B, and produces two outputs. It can insert dead time so that complementary power switches never conduct at the same time.

The block has two delay paths:
- A rising-edge path holds back the low-to-high transition of its source.
- A falling-edge path holds back the high-to-low transition of its source.

A control word sets up the routing. Each path takes its source from A or from B. Each path can drive its output or be bypassed so that the raw input passes through. Each delayed result can be inverted on its way out. Two further registers hold the delay lengths in clock cycles. A small synchronous register port writes and reads all three registers.

Top module: `pwm_deadband`

## Requirements
- R1: After the synchronous reset, all three registers read zero. Both outputs are held low while reset is asserted.
- R2: The register map is as follows:
  - Address 0 is the control word, bits 5:0. Bits 15:6 read zero.
  - Address 1 is the rising delay and address 2 is the falling delay. Each delay occupies bits 9:0, and bits 15:10 read zero.
  - Address 3 reads zero.
- R3: When control bits 1:0 are 0, out A equals in A and out B equals in B in the same cycle. All other control bits have no effect in this case.
- R4: Control bit 4 selects the rising-path source and control bit 5 selects the falling-path source. In each bit, 0 means A and 1 means B.
- R5: The rising path output goes high once its source has been high for as many consecutive earlier cycles as the rising delay. It falls in the same cycle as its source falls.
- R6: The falling path output stays high until its source has been low for as many consecutive earlier cycles as the falling delay. It rises in the same cycle as its source rises.
- R7: A source pulse that is no longer than the rising delay never appears on the rising path. A low gap that is no longer than the falling delay never appears on the falling path.
- R8: A delay of zero adds no latency, so that path's output equals its source.
- R9: Polarity depends on which output carries a delayed path:
  - Control bit 2 inverts out A when out A carries the rising path.
  - Control bit 3 inverts out B when out B carries the falling path.
- R10: Output routing depends on control bits 1 and 0:
  - Control bit 1 set routes the rising path to out A; otherwise out A equals in A.
  - Control bit 0 set routes the falling path to out B; otherwise out B equals in B.
- R11: A register write takes effect on the clock edge that ends the write cycle. During the write cycle itself, reads and outputs still reflect the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr, combinational |
| a_in | input | 1 | PWM input A |
| b_in | input | 1 | PWM input B |
| a_out | output | 1 | PWM output A |
| b_out | output | 1 | PWM output B |

## Verification
Two events can land in the same cycle:
- A delay counter expiring, which releases the delayed edge.
- A source transition that cancels that edge.

The sweep provokes this by driving randomly toggling inputs through all 64 control words with several delay pairs, including zero delays. The toggle rate is chosen so that pulses routinely land just below, at, and just above the programmed delay. Each cycle is judged against a bench model that counts consecutive high and low cycles per input and derives both outputs arithmetically. This catches any off-by-one between expiry and cancellation.

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int CNT_W = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        a_in,
  input  logic        b_in,
  output logic        a_out,
  output logic        b_out
);

  localparam logic [CNT_W-1:0] ONE = 1;

  logic [5:0]       ctl;
  logic [CNT_W-1:0] rise_dly, fall_dly;
  logic [CNT_W-1:0] rise_rem, fall_rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      rise_dly <= '0;
      fall_dly <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: ctl <= wr_data[5:0];
        2'd1: rise_dly <= wr_data[CNT_W-1:0];
        2'd2: fall_dly <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rd_data = {10'd0, ctl};
      2'd1:    rd_data = 16'(rise_dly);
      2'd2:    rd_data = 16'(fall_dly);
      default: rd_data = '0;
    endcase
  end

  wire rise_src = ctl[4] ? b_in : a_in;
  wire fall_src = ctl[5] ? b_in : a_in;

  always_ff @(posedge clk) begin
    if (rst)                 rise_rem <= '0;
    else if (!rise_src)      rise_rem <= rise_dly;
    else if (rise_rem != '0) rise_rem <= rise_rem - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)                 fall_rem <= '0;
    else if (fall_src)       fall_rem <= fall_dly;
    else if (fall_rem != '0) fall_rem <= fall_rem - ONE;
  end

  wire rise_dl = rise_src & (rise_rem == '0);
  wire fall_dl = fall_src | (fall_rem != '0);

  wire a_sel = ctl[1] ? (rise_dl ^ ctl[2]) : a_in;
  wire b_sel = ctl[0] ? (fall_dl ^ ctl[3]) : b_in;

  assign a_out = ~rst & a_sel;
  assign b_out = ~rst & b_sel;

  p_rst_low_r1: assert property (@(posedge clk) rst |-> !a_out && !b_out);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    addr == 2'd0 |-> rd_data[15:6] == '0);

  p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    ctl[1:0] == 2'b00 |-> a_out == a_in && b_out == b_in);

  p_rise_drop_r5: assert property (@(posedge clk) disable iff (rst)
    ctl[1] && !ctl[2] && !rise_src |-> !a_out);

  p_fall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ctl[0] && !ctl[3] && fall_src |-> b_out);

  p_rise_wait_r7: assert property (@(posedge clk) disable iff (rst)
    ctl[1] && !ctl[2] && rise_rem != '0 |-> !a_out);

  p_pass_a_r10: assert property (@(posedge clk) disable iff (rst)
    !ctl[1] |-> a_out == a_in);

  p_write_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wr_en && addr == 2'd1) |-> rise_dly == $past(wr_data[CNT_W-1:0]));

endmodule

// File: tb/tb_pwm_deadband.sv
module tb_pwm_deadband;
  logic clk = 0, rst = 1, wr_en = 0, a_in = 0, b_in = 0;
  logic [1:0] addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic a_out, b_out;

  pwm_deadband dut (.clk, .rst, .wr_en, .addr, .wr_data, .rd_data,
                    .a_in, .b_in, .a_out, .b_out);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int hi_a = 1023, lo_a = 1023, hi_b = 1023, lo_b = 1023;
  logic [5:0] m_ctl = 0;
  int m_rd = 0, m_fd = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(input int v);
    return (v >= 1023) ? 1023 : v + 1;
  endfunction

  task automatic cyc(input logic a, input logic b, input logic we,
                     input logic [1:0] ad, input logic [15:0] wd, input bit check);
    logic rs, fs, red, fed, ea, eb;
    int rh, fl;
    @(negedge clk);
    a_in = a; b_in = b; wr_en = we; addr = ad; wr_data = wd;
    #5;
    if (check) begin
      rs  = m_ctl[4] ? b : a;
      rh  = m_ctl[4] ? hi_b : hi_a;
      fs  = m_ctl[5] ? b : a;
      fl  = m_ctl[5] ? lo_b : lo_a;
      red = rs && (rh >= m_rd);
      fed = fs || (fl < m_fd);
      ea  = m_ctl[1] ? (red ^ m_ctl[2]) : a;
      eb  = m_ctl[0] ? (fed ^ m_ctl[3]) : b;
      chk(m_ctl[1] ? "R4 R5 R7 R8 R9 a_out" : (m_ctl[1:0] == 0 ? "R3 a_out" : "R10 a_out"),
          int'(a_out), int'(ea));
      chk(m_ctl[0] ? "R4 R6 R7 R8 R9 b_out" : (m_ctl[1:0] == 0 ? "R3 b_out" : "R10 b_out"),
          int'(b_out), int'(eb));
    end
    @(posedge clk); #1;
    hi_a = a ? sat(hi_a) : 0;  lo_a = a ? 0 : sat(lo_a);
    hi_b = b ? sat(hi_b) : 0;  lo_b = b ? 0 : sat(lo_b);
    if (we) case (ad)
      2'd0: m_ctl = wd[5:0];
      2'd1: m_rd  = int'(wd[9:0]);
      2'd2: m_fd  = int'(wd[9:0]);
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [1:0] ad, input int exp, input string req);
    @(negedge clk);
    wr_en = 0; addr = ad;
    #5 chk(req, int'(rd_data), exp);
  endtask

  initial begin
    logic a, b;
    int rds[4] = '{0, 3, 1, 5};
    int fds[4] = '{0, 2, 4, 0};
    // R1: outputs low during reset even with inputs high
    a_in = 1; b_in = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 a_out in reset", int'(a_out), 0);
    chk("R1 b_out in reset", int'(b_out), 0);
    rst = 0; a_in = 0; b_in = 0;
    rd_chk(2'd0, 0, "R1 ctl reset");
    rd_chk(2'd1, 0, "R1 rise reset");
    rd_chk(2'd2, 0, "R1 fall reset");
    // R2: reserved bits and widths
    cyc(0, 0, 1, 2'd0, 16'hFFFF, 0);
    cyc(0, 0, 1, 2'd1, 16'hFFFF, 0);
    cyc(0, 0, 1, 2'd2, 16'hFFFF, 0);
    rd_chk(2'd0, 16'h003F, "R2 ctl read");
    rd_chk(2'd1, 16'h03FF, "R2 rise read");
    rd_chk(2'd2, 16'h03FF, "R2 fall read");
    rd_chk(2'd3, 0, "R2 addr3 read");
    // R11: old value visible during the write cycle, new after
    @(negedge clk);
    wr_en = 1; addr = 2'd1; wr_data = 16'd7;
    #5 chk("R11 during write", int'(rd_data), 16'h03FF);
    @(posedge clk); #1 wr_en = 0;
    m_rd = 7;
    rd_chk(2'd1, 7, "R11 after write");
    // sweep of all control words and several delay pairs
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 64; c++) begin
        cyc(0, 0, 1, 2'd0, 16'(c), 0);
        cyc(0, 0, 1, 2'd1, 16'(rds[p]), 0);
        cyc(0, 0, 1, 2'd2, 16'(fds[p]), 0);
        cyc(0, 0, 0, 2'd0, 16'd0, 0);
        cyc(1, 1, 0, 2'd0, 16'd0, 0);
        a = 1; b = 1;
        for (int k = 0; k < 40; k++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          if (lfsr[1:0] == 2'b00) a = ~a;
          if (lfsr[5:4] == 2'b00) b = ~b;
          cyc(a, b, 0, 2'd0, 16'd0, 1);
        end
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule